// File: doc/BRIEF.md
# FIFO Service and Error Flag Unit

This unit sits beside the transmit and receive word FIFOs of a serial controller and turns their occupancy and traffic into status for software. It registers the level bits (not-empty and full for each FIFO). It counts the words moved in each direction for the current transfer and raises service requests and completion flags. It also latches sticky error flags when a FIFO is pushed while full or popped while empty, and when the serial shifter reports a clock over-run or under-run. The FIFO storage and the shifter are outside the unit. They report their occupancy counts and one-cycle event strobes to it.

A transfer begins with a one-cycle `start` pulse carrying the transfer length in words. If the length fits in the receive FIFO, the unit works in burst mode and raises a single service request per direction, when that direction completes. Otherwise it works in block mode and requests service every `BLOCK` words. Software clears sticky flags by writing ones over them. A per-bit enable decides which error flags drive the interrupt. The interrupt is a registered, active-high level.

Top module: `fifo_svc_flags`

## Requirements
- R1: After synchronous reset, every status, error and enable bit is 0, `blk_mode` is 0 and `irq` is low.
- R2: `op_status` bits 4 (transmit not empty), 5 (receive not empty), 6 (transmit full, count equal to OUT_DEPTH) and 7 (receive full, count equal to IN_DEPTH) follow `out_count`/`in_count` one clock later and cannot be cleared by software.
- R3: On `start`, `blk_mode` becomes 0 (burst mode) when `xfer_words` is at most IN_DEPTH, and 1 (block mode) otherwise. Events in the `start` cycle are not counted.
- R4: `op_status` bit 10 sets when the `xfer_words`-th `out_pop` of the transfer occurs, and bit 11 sets when the `xfer_words`-th `in_push` occurs. Further events are not counted.
- R5: In burst mode, service request bits 8 (transmit) and 9 (receive) set only together with the matching completion.
- R6: In block mode, bit 9 sets on every BLOCK-th `in_push` and bit 8 sets on every BLOCK-th `out_pop` of the transfer, as well as on completion.
- R7: `fifo_err` bit 5 latches on `out_push` while the transmit FIFO is full. Bit 3 latches on `out_pop` while the transmit FIFO is empty.
- R8: `fifo_err` bit 2 latches on `in_push` while the receive FIFO is full. Bit 4 latches on `in_pop` while the receive FIFO is empty.
- R9: `ser_err` bit 0 latches on `sclk_under` and bit 1 latches on `sclk_over`.
- R10: Sticky bits (op_status 11:8, fifo_err, ser_err) are cleared only by writing a 1 to them. Zero bits in the write data leave the flags unchanged. A flag set in the same cycle as its clear stays set.
- R11: `irq` is the OR of the enabled error flags and op_status bits 8 and 9. It updates in the same cycle as the flags. A disabled error still latches but does not raise `irq`.
- R12: A write with `wr_en` uses `wr_sel`: 0 clears op_status bits from `wr_data[11:8]`, 1 clears fifo errors from `wr_data[5:0]`, 2 clears serial errors from `wr_data[1:0]`, 3 loads the fifo error enables from `wr_data[5:2]`, and 4 loads the serial error enables from `wr_data[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer; samples `xfer_words` |
| xfer_words | input | CNT_W | Transfer length in words |
| out_count | input | $clog2(OUT_DEPTH+1) | Transmit FIFO occupancy |
| in_count | input | $clog2(IN_DEPTH+1) | Receive FIFO occupancy |
| out_push | input | 1 | Software wrote a transmit word |
| out_pop | input | 1 | Shifter took a transmit word |
| in_push | input | 1 | Shifter deposited a receive word |
| in_pop | input | 1 | Software read a receive word |
| sclk_over | input | 1 | Serial clock over-run strobe |
| sclk_under | input | 1 | Serial clock under-run strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write target |
| wr_data | input | 12 | Register write data |
| op_status | output | 12 | Level, service and completion flags |
| fifo_err | output | 6 | Sticky FIFO error flags |
| ser_err | output | 2 | Sticky serial clock error flags |
| blk_mode | output | 1 | 1 when the transfer runs in block mode |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest case to reach is the boundary between block-mode service requests and completion. The bench needs a block-mode transfer long enough for several block requests, with the flag cleared between them so that each new request is visible on its own. It then runs the same counter up to the full length and drives further pushes to show that the counter stops. The same-cycle race between a flag being set and software clearing it is reached by driving a full-FIFO push in the same cycle as the write-one-to-clear.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  typedef enum logic [2:0] {
    SEL_OP_CLR   = 3'd0,
    SEL_FERR_CLR = 3'd1,
    SEL_SERR_CLR = 3'd2,
    SEL_FERR_EN  = 3'd3,
    SEL_SERR_EN  = 3'd4
  } wr_sel_e;

  localparam int OP_W   = 12;
  localparam int FERR_W = 6;
  localparam int SERR_W = 2;
  // fifo error bits that exist; bits 1:0 are reserved
  localparam logic [FERR_W-1:0] FERR_MASK = 6'b111100;
endpackage

// File: rtl/fsf_dir_tracker.sv
module fsf_dir_tracker #(
  parameter int CNT_W = 16,
  parameter int BLOCK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] total,
  input  logic             blk_mode,
  input  logic             evt,
  output logic             done_evt,
  output logic             svc_evt
);
  localparam int BW = $clog2(BLOCK + 1);

  logic [CNT_W-1:0] cnt;
  logic [BW-1:0]    blk;
  logic             take, blk_hit;

  always_comb begin
    take     = evt && !start && (cnt < total);
    done_evt = take && ((cnt + 1'b1) == total);
    blk_hit  = take && blk_mode && (blk == BW'(BLOCK - 1));
    svc_evt  = done_evt || blk_hit;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
      blk <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      blk <= blk_hit ? '0 : blk + 1'b1;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= total);
  assert_block_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    blk < BW'(BLOCK));
endmodule

// File: rtl/fsf_sticky_w1c.sv
module fsf_sticky_w1c #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic         en_we,
  input  logic [W-1:0] en_bits,
  output logic [W-1:0] flags,
  output logic [W-1:0] en,
  output logic         pend_next
);
  logic [W-1:0] flags_d, en_d;

  always_comb begin
    flags_d   = (flags & ~(clr_we ? clr_bits : '0)) | set;
    en_d      = en_we ? en_bits : en;
    pend_next = |(flags_d & en_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      en    <= '0;
    end else begin
      flags <= flags_d;
      en    <= en_d;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_w1c_clear_R10: assert property (@(posedge clk) disable iff (rst)
      clr_we && clr_bits[i] && !set[i] |=> !flags[i]);
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
      flags[i] && !(clr_we && clr_bits[i]) |=> flags[i]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
  end
endmodule

// File: rtl/fifo_svc_flags.sv
module fifo_svc_flags
  import fsf_pkg::*;
#(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 16,
  parameter int BLOCK     = 4,
  parameter int CNT_W     = 16,
  localparam int OCW      = $clog2(OUT_DEPTH + 1),
  localparam int ICW      = $clog2(IN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  xfer_words,
  input  logic [OCW-1:0]    out_count,
  input  logic [ICW-1:0]    in_count,
  input  logic              out_push,
  input  logic              out_pop,
  input  logic              in_push,
  input  logic              in_pop,
  input  logic              sclk_over,
  input  logic              sclk_under,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [OP_W-1:0]   wr_data,
  output logic [OP_W-1:0]   op_status,
  output logic [FERR_W-1:0] fifo_err,
  output logic [SERR_W-1:0] ser_err,
  output logic              blk_mode,
  output logic              irq
);
  logic [CNT_W-1:0] total_q;
  logic [3:0]       lvl_q;     // {in_full, out_full, in_ne, out_ne}
  logic [3:0]       op_q;      // {in_done, out_done, in_svc, out_svc}
  logic [3:0]       op_d, op_set;
  logic             out_done, out_svc, in_done, in_svc;
  logic             out_full, out_empty, in_full, in_empty;
  logic [FERR_W-1:0] ferr_set, ferr_en;
  logic [SERR_W-1:0] serr_en;
  logic             ferr_pend, serr_pend;
  logic             clr_op, clr_fe, clr_se, ld_fe, ld_se;

  always_comb begin
    out_full  = (out_count == OCW'(OUT_DEPTH));
    out_empty = (out_count == '0);
    in_full   = (in_count == ICW'(IN_DEPTH));
    in_empty  = (in_count == '0);
    clr_op = wr_en && (wr_sel == SEL_OP_CLR);
    clr_fe = wr_en && (wr_sel == SEL_FERR_CLR);
    clr_se = wr_en && (wr_sel == SEL_SERR_CLR);
    ld_fe  = wr_en && (wr_sel == SEL_FERR_EN);
    ld_se  = wr_en && (wr_sel == SEL_SERR_EN);
    ferr_set = {out_push && out_full, in_pop && in_empty,
                out_pop && out_empty, in_push && in_full, 2'b00};
    op_set = {in_done, out_done, in_svc, out_svc};
    op_d   = (op_q & ~(clr_op ? wr_data[11:8] : 4'b0)) | op_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q  <= '0;
      blk_mode <= 1'b0;
      lvl_q    <= '0;
      op_q     <= '0;
      irq      <= 1'b0;
    end else begin
      if (start) begin
        total_q  <= xfer_words;
        blk_mode <= (xfer_words > CNT_W'(IN_DEPTH));
      end
      lvl_q <= {in_full, out_full, !in_empty, !out_empty};
      op_q  <= op_d;
      irq   <= ferr_pend || serr_pend || op_d[0] || op_d[1];
    end
  end

  assign op_status = {op_q, lvl_q, 4'b0000};

  fsf_dir_tracker #(.CNT_W(CNT_W), .BLOCK(BLOCK)) u_tx (
    .clk(clk), .rst(rst), .start(start), .total(total_q), .blk_mode(blk_mode),
    .evt(out_pop), .done_evt(out_done), .svc_evt(out_svc));

  fsf_dir_tracker #(.CNT_W(CNT_W), .BLOCK(BLOCK)) u_rx (
    .clk(clk), .rst(rst), .start(start), .total(total_q), .blk_mode(blk_mode),
    .evt(in_push), .done_evt(in_done), .svc_evt(in_svc));

  fsf_sticky_w1c #(.W(FERR_W)) u_ferr (
    .clk(clk), .rst(rst), .set(ferr_set), .clr_we(clr_fe),
    .clr_bits(wr_data[FERR_W-1:0]), .en_we(ld_fe),
    .en_bits(wr_data[FERR_W-1:0] & FERR_MASK),
    .flags(fifo_err), .en(ferr_en), .pend_next(ferr_pend));

  fsf_sticky_w1c #(.W(SERR_W)) u_serr (
    .clk(clk), .rst(rst), .set({sclk_over, sclk_under}), .clr_we(clr_se),
    .clr_bits(wr_data[SERR_W-1:0]), .en_we(ld_se),
    .en_bits(wr_data[SERR_W-1:0]),
    .flags(ser_err), .en(serr_en), .pend_next(serr_pend));

  assert_mode_pick_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> blk_mode == ($past(xfer_words) > CNT_W'(IN_DEPTH)));
  assert_out_full_R2: assert property (@(posedge clk) disable iff (rst)
    out_count == OCW'(OUT_DEPTH) |=> op_status[6] && op_status[4]);
  assert_out_ovr_R7: assert property (@(posedge clk) disable iff (rst)
    out_push && out_count == OCW'(OUT_DEPTH) |=> fifo_err[5]);
  assert_in_und_R8: assert property (@(posedge clk) disable iff (rst)
    in_pop && in_count == '0 |=> fifo_err[4]);
  assert_burst_svc_R5: assert property (@(posedge clk) disable iff (rst)
    !blk_mode && $rose(op_status[9]) |-> op_status[11]);
  assert_svc_irq_R11: assert property (@(posedge clk) disable iff (rst)
    (op_status[8] || op_status[9]) |-> irq);
endmodule

// File: tb/fifo_svc_flags_test.sv
module fifo_svc_flags_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0;
  logic [15:0] xfer_words = 0;
  logic [4:0] out_count = 5, in_count = 0;
  logic out_push = 0, out_pop = 0, in_push = 0, in_pop = 0;
  logic sclk_over = 0, sclk_under = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [11:0] wr_data = 0;
  logic [11:0] op_status;
  logic [5:0] fifo_err;
  logic [1:0] ser_err;
  logic blk_mode, irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fifo_svc_flags uut (
    .clk(clk), .rst(rst), .start(start), .xfer_words(xfer_words),
    .out_count(out_count), .in_count(in_count), .out_push(out_push),
    .out_pop(out_pop), .in_push(in_push), .in_pop(in_pop),
    .sclk_over(sclk_over), .sclk_under(sclk_under), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .op_status(op_status),
    .fifo_err(fifo_err), .ser_err(ser_err), .blk_mode(blk_mode), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock edge, then clear all strobes
  task automatic step();
    @(posedge clk); #1;
    start = 0; out_push = 0; out_pop = 0; in_push = 0; in_pop = 0;
    sclk_over = 0; sclk_under = 0; wr_en = 0;
  endtask

  task automatic wr(logic [2:0] sel, logic [11:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; step();
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) step(); rst = 0;
    chk("R1 op_status", op_status, 0);
    chk("R1 fifo_err", fifo_err, 0);
    chk("R1 ser_err", ser_err, 0);
    chk("R1 blk_mode", blk_mode, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_levels();
    out_count = 16; in_count = 16; step();
    chk("R2 both full", op_status[7:4], 4'hF);
    out_count = 0; in_count = 3; step();
    chk("R2 rx ne only", op_status[7:4], 4'h2);
    wr(0, 12'h0F0);
    chk("R2 levels not clearable", op_status[7:4], 4'h2);
    out_count = 5; in_count = 0; step();
    chk("R2 tx ne only", op_status[7:4], 4'h1);
  endtask

  task automatic t_burst();
    start = 1; xfer_words = 3; in_push = 1; step();
    chk("R3 burst mode", blk_mode, 0);
    in_push = 1; step(); in_push = 1; step();
    chk("R5 no svc before done", op_status[11:8], 0);
    in_push = 1; step();
    chk("R4 rx done+svc", op_status[11:8], 4'b1010);
    chk("R11 irq from svc", irq, 1);
    repeat (3) begin out_pop = 1; step(); end
    chk("R4 tx done+svc", op_status[11:8], 4'b1111);
    wr(0, 12'hF00);
    chk("R10 op cleared", op_status[11:8], 0);
    chk("R11 irq dropped", irq, 0);
  endtask

  task automatic t_block();
    start = 1; xfer_words = 17; step();
    chk("R3 block mode", blk_mode, 1);
    repeat (3) begin in_push = 1; step(); end
    chk("R6 no svc at 3", op_status[9], 0);
    in_push = 1; step();
    chk("R6 rx svc at 4", op_status[9], 1);
    wr(0, 12'h200);
    repeat (4) begin in_push = 1; step(); end
    chk("R6 rx svc at 8", op_status[9], 1);
    chk("R4 rx not done at 8", op_status[11], 0);
    repeat (4) begin out_pop = 1; step(); end
    chk("R6 tx svc at 4", op_status[8], 1);
    wr(0, 12'hF00);
    repeat (9) begin in_push = 1; step(); end
    chk("R4 rx done at 17", op_status[11], 1);
    wr(0, 12'hF00);
    repeat (3) begin in_push = 1; step(); end
    chk("R4 no count past end", op_status[11:8], 0);
    start = 1; xfer_words = 16; step();
    chk("R3 boundary burst", blk_mode, 0);
  endtask

  task automatic t_fifo_err();
    out_count = 16; out_push = 1; step();
    chk("R7 tx overrun", fifo_err, 6'h20);
    chk("R11 disabled no irq", irq, 0);
    wr(3, 12'h03C);
    chk("R12 enable raises irq", irq, 1);
    out_count = 0; out_pop = 1; step();
    chk("R7 tx underrun", fifo_err, 6'h28);
    wr(1, 12'h000);
    chk("R10 zero write no effect", fifo_err, 6'h28);
    wr(1, 12'h020);
    chk("R10 selective clear", fifo_err, 6'h08);
    out_count = 16; out_push = 1; wr(1, 12'h028);
    chk("R10 set wins over clear", fifo_err, 6'h20);
    wr(1, 12'h020);
    chk("R11 irq off after clear", irq, 0);
    in_count = 16; in_push = 1; step();
    chk("R8 rx overrun", fifo_err, 6'h04);
    in_count = 0; in_pop = 1; step();
    chk("R8 rx underrun", fifo_err, 6'h14);
    wr(1, 12'h03F);
    chk("R10 all fifo cleared", fifo_err, 0);
    out_count = 5;
  endtask

  task automatic t_serial();
    sclk_under = 1; step();
    chk("R9 clk under-run", ser_err, 2'b01);
    chk("R11 serial disabled", irq, 0);
    wr(4, 12'h003);
    chk("R12 serial enable irq", irq, 1);
    sclk_over = 1; step();
    chk("R9 clk over-run", ser_err, 2'b11);
    wr(2, 12'h001);
    chk("R10 serial partial clear", ser_err, 2'b10);
    wr(2, 12'h002);
    chk("R11 irq idle", irq, 0);
  endtask

  initial begin
    t_reset();
    t_levels();
    t_burst();
    t_block();
    t_fifo_err();
    t_serial();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule